// File: doc/BRIEF.md
# Nonvolatile Memory Control Register

This block is the 8-bit control and status register that a CPU uses to run read, write and row-erase operations on an on-chip nonvolatile store. Software selects the target space, arms a write-enable gate, optionally arms a row erase, and then sets a start bit. The block issues a read strobe, or holds a write or erase request toward the storage, until the operation is done. Software can only set the start bits. Hardware clears them when the operation ends.

The register is built around a four-state sequencer. The states are `ST_IDLE`, `ST_READ`, `ST_PROG` and `ST_ERASE`. The transitions are:
- idle to read on an accepted read start;
- idle to prog on an accepted write start with the erase bit clear;
- idle to erase on an accepted write start with the erase bit set;
- read to idle after one cycle;
- prog or erase to idle on completion;
- prog or erase to idle on abort.

A self-timed operation completes when either of two things happens first: the storage's done pulse arrives, or an internal timer of `PROG_CYCLES` cycles expires. With `PROG_CYCLES = 0` the timer is left out, and only the done pulse ends the operation. There are two resets. A power-on reset clears everything. A synchronous warm reset aborts a self-timed operation, and that abort sets a sticky error flag.

Top module: `nvm_ctl_reg`

## Requirements
- R1: The readback byte is {prog_sel[7], cfg_sel[6], 0[5], erase_arm[4], err[3], wr_en[2], wr_go[1], rd_go[0]}. A CPU write updates bits 7, 6, 4 and 2 directly. Bit 5 always reads 0, and a CPU write never sets err.
- R2: While power-on reset `por_n` is low, the register reads 0x00 and every storage-side output is 0.
- R3: A CPU write with bit 0 = 1 and bit 1 = 0, made while idle with stored prog_sel = 0, sets rd_go and `nvm_rd_strobe` for exactly one cycle. Both clear on the next cycle.
- R4: A read start is ignored while the stored prog_sel is 1. rd_go stays 0 and no strobe is issued.
- R5: The start bits are set-only from software. Writing 0 to bit 1 while wr_go is 1 leaves it at 1. A read start during a busy write is ignored.
- R6: A write start (bit 1 = 1) is accepted only if the stored wr_en is already 1. Otherwise wr_go stays 0 and neither `nvm_write_req` nor `nvm_erase_req` rises.
- R7: An accepted write start with erase_arm = 0 holds wr_go and `nvm_write_req` high. They fall after a `nvm_done` pulse, or after `PROG_CYCLES` cycles, whichever comes first.
- R8: If erase_arm was 1 when the write start was accepted, `nvm_erase_req` is raised instead, and erase_arm is cleared when that erase completes.
- R9: A `warm_rst` pulse during a write or erase drops the request, clears wr_go and sets err. prog_sel and cfg_sel keep their values.
- R10: A `warm_rst` pulse while no self-timed operation is running leaves err unchanged.
- R11: A completed write or erase clears err.
- R12: A `nvm_done` pulse while wr_go is 0 has no effect on the register.
- R13: A CPU write with bits 1 and 0 both set starts only the write. The read request is dropped.
- R14: `nvm_target` is 2'b10 when cfg_sel is 1, otherwise 2'b01 when prog_sel is 1, otherwise 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register readback |
| nvm_rd_strobe | output | 1 | One-cycle read strobe to storage |
| nvm_write_req | output | 1 | Write request held for the operation |
| nvm_erase_req | output | 1 | Row-erase request held for the operation |
| nvm_target | output | 2 | Selected target space |
| nvm_done | input | 1 | Completion pulse from storage |

## Verification
The bench builds the block with `PROG_CYCLES = 12`. That keeps timer expiry within reach, so the bench can check both the exact cycle at which an undisturbed write ends and a done pulse that ends a write early. The default of 64 and the timer-less variant are only elaborated. With the short timer, every abort, erase and error-clearing case completes within a few dozen cycles.

// File: rtl/nvm_ctl_pkg.sv
package nvm_ctl_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned B_PSEL = 7;
    localparam int unsigned B_CSEL = 6;
    localparam int unsigned B_ARM  = 4;
    localparam int unsigned B_ERR  = 3;
    localparam int unsigned B_WEN  = 2;
    localparam int unsigned B_WR   = 1;
    localparam int unsigned B_RD   = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_PROG  = 2'd2,
        ST_ERASE = 2'd3
    } nvm_state_e;

    typedef enum logic [1:0] {
        TGT_DATA = 2'b00,
        TGT_PROG = 2'b01,
        TGT_CFG  = 2'b10
    } nvm_target_e;
endpackage

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int unsigned CYCLES = 64
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == LAST);
endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
    import nvm_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       warm,
    input  logic       req_rd,
    input  logic       req_wr,
    input  logic       erase_sel,
    input  logic       done,
    output logic       ev_start_rd,
    output logic       ev_start_wr,
    output logic       ev_finish,
    output logic       ev_abort,
    output logic       rd_strobe,
    output logic       wr_level,
    output logic       er_level
);
    nvm_state_e state, state_nx;
    logic busy;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!warm) begin
                    if (req_wr)      state_nx = erase_sel ? ST_ERASE : ST_PROG;
                    else if (req_rd) state_nx = ST_READ;
                end
            end
            ST_READ:  state_nx = ST_IDLE;
            ST_PROG,
            ST_ERASE: if (warm || done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_strobe   = (state == ST_READ);
        wr_level    = (state == ST_PROG);
        er_level    = (state == ST_ERASE);
        busy        = wr_level || er_level;
        ev_start_wr = (state == ST_IDLE) && !warm && req_wr;
        ev_start_rd = (state == ST_IDLE) && !warm && !req_wr && req_rd;
        ev_finish   = busy && !warm && done;
        ev_abort    = busy && warm;
    end
endmodule

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
    import nvm_ctl_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 64
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst,
    input  logic             cpu_we,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    output logic             nvm_rd_strobe,
    output logic             nvm_write_req,
    output logic             nvm_erase_req,
    output logic [1:0]       nvm_target,
    input  logic             nvm_done
);
    logic prog_sel, cfg_sel, erase_arm, err, wr_en, wr_go, rd_go;
    logic req_rd, req_wr, tmr_expire, done_hit;
    logic ev_start_rd, ev_start_wr, ev_finish, ev_abort;
    logic unused_bits;

    assign unused_bits = ^{cpu_wdata[5], cpu_wdata[B_ERR]};

    // A write start suppresses any read request in the same byte.
    assign req_wr   = cpu_we && cpu_wdata[B_WR] && wr_en;
    assign req_rd   = cpu_we && cpu_wdata[B_RD] && !cpu_wdata[B_WR] && !prog_sel;
    assign done_hit = wr_go && (nvm_done || tmr_expire);

    generate
        if (PROG_CYCLES > 0) begin : g_timer
            nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
                .clk    (clk),
                .por_n  (por_n),
                .run    (nvm_write_req || nvm_erase_req),
                .expire (tmr_expire)
            );
        end else begin : g_no_timer
            assign tmr_expire = 1'b0;
        end
    endgenerate

    nvm_seq_fsm u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .warm        (warm_rst),
        .req_rd      (req_rd),
        .req_wr      (req_wr),
        .erase_sel   (erase_arm),
        .done        (done_hit),
        .ev_start_rd (ev_start_rd),
        .ev_start_wr (ev_start_wr),
        .ev_finish   (ev_finish),
        .ev_abort    (ev_abort),
        .rd_strobe   (nvm_rd_strobe),
        .wr_level    (nvm_write_req),
        .er_level    (nvm_erase_req)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prog_sel  <= 1'b0;
            cfg_sel   <= 1'b0;
            erase_arm <= 1'b0;
            err       <= 1'b0;
            wr_en     <= 1'b0;
            wr_go     <= 1'b0;
            rd_go     <= 1'b0;
        end else begin
            if (cpu_we) begin
                prog_sel  <= cpu_wdata[B_PSEL];
                cfg_sel   <= cpu_wdata[B_CSEL];
                erase_arm <= cpu_wdata[B_ARM];
                wr_en     <= cpu_wdata[B_WEN];
            end
            if (ev_finish && nvm_erase_req) erase_arm <= 1'b0;

            if (ev_abort || ev_finish) wr_go <= 1'b0;
            else if (ev_start_wr)      wr_go <= 1'b1;

            if (warm_rst)           rd_go <= 1'b0;
            else if (ev_start_rd)   rd_go <= 1'b1;
            else if (nvm_rd_strobe) rd_go <= 1'b0;

            if (ev_abort)       err <= 1'b1;
            else if (ev_finish) err <= 1'b0;
        end
    end

    assign cpu_rdata  = {prog_sel, cfg_sel, 1'b0, erase_arm, err, wr_en, wr_go, rd_go};
    assign nvm_target = cfg_sel  ? TGT_CFG :
                        prog_sel ? TGT_PROG : TGT_DATA;
endmodule

// File: rtl/nvm_ctl_reg_chk.sv
module nvm_ctl_reg_chk (
    input logic       clk,
    input logic       por_n,
    input logic       warm_rst,
    input logic       cpu_we,
    input logic [7:0] cpu_rdata,
    input logic       nvm_erase_req,
    input logic       nvm_done
);
    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rdata[0] |=> !cpu_rdata[0]);

    // R4
    rd_refuse_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cpu_rdata[0]) |-> !$past(cpu_rdata[7]));

    // R6
    wr_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cpu_rdata[1]) |-> $past(cpu_rdata[2]));

    // R9
    abort_err_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_rdata[1] && warm_rst) |=> (cpu_rdata[3] && !cpu_rdata[1]));

    // R9
    abort_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_rdata[1] && warm_rst && !cpu_we) |=> $stable(cpu_rdata[7:6]));

    // R8
    erase_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
        (nvm_erase_req && nvm_done && !warm_rst) |=> !cpu_rdata[4]);

    // R12
    done_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!cpu_rdata[1] && !cpu_rdata[0] && nvm_done && !cpu_we && !warm_rst)
        |=> $stable(cpu_rdata));
endmodule

bind nvm_ctl_reg nvm_ctl_reg_chk u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .warm_rst      (warm_rst),
    .cpu_we        (cpu_we),
    .cpu_rdata     (cpu_rdata),
    .nvm_erase_req (nvm_erase_req),
    .nvm_done      (nvm_done)
);

// File: tb/nvm_ctl_reg_tb.sv
`timescale 1ns/1ps
module nvm_ctl_reg_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_rst = 1'b0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       nvm_rd_strobe, nvm_write_req, nvm_erase_req, nvm_done = 1'b0;
    logic [1:0] nvm_target;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nvm_ctl_reg #(.PROG_CYCLES(12)) u_dut (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .nvm_rd_strobe(nvm_rd_strobe), .nvm_write_req(nvm_write_req),
        .nvm_erase_req(nvm_erase_req), .nvm_target(nvm_target),
        .nvm_done(nvm_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_wr(input logic [7:0] v);
        cpu_we = 1'b1; cpu_wdata = v;
        @(negedge clk);
        cpu_we = 1'b0; cpu_wdata = 8'h00;
    endtask

    task automatic done_pulse();
        nvm_done = 1'b1;
        @(negedge clk);
        nvm_done = 1'b0;
    endtask

    task automatic warm_pulse();
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 rdata", cpu_rdata, 8'h00);
        chk("R2 outputs", {nvm_rd_strobe, nvm_write_req, nvm_erase_req, nvm_target}, 0);
    endtask

    task automatic t_layout();
        cpu_wr(8'hFF);
        chk("R1 layout", cpu_rdata, 8'hD4);
        cpu_wr(8'h00);
        chk("R1 cleared", cpu_rdata, 8'h00);
    endtask

    task automatic t_target();
        cpu_wr(8'h80); chk("R14 prog", nvm_target, 2'b01);
        cpu_wr(8'hC0); chk("R14 cfg over prog", nvm_target, 2'b10);
        cpu_wr(8'h40); chk("R14 cfg", nvm_target, 2'b10);
        cpu_wr(8'h00); chk("R14 data", nvm_target, 2'b00);
    endtask

    task automatic t_read();
        cpu_wr(8'h01);
        chk("R3 rd set", cpu_rdata, 8'h01);
        chk("R3 strobe", nvm_rd_strobe, 1'b1);
        step(1);
        chk("R3 rd cleared", cpu_rdata, 8'h00);
        chk("R3 strobe off", nvm_rd_strobe, 1'b0);
    endtask

    task automatic t_read_refused();
        cpu_wr(8'h80);
        cpu_wr(8'h81);
        chk("R4 rd refused", cpu_rdata, 8'h80);
        chk("R4 no strobe", nvm_rd_strobe, 1'b0);
        cpu_wr(8'h00);
    endtask

    task automatic t_wen_block();
        cpu_wr(8'h02);
        chk("R6 wr blocked", cpu_rdata, 8'h00);
        chk("R6 no write req", nvm_write_req, 1'b0);
        cpu_wr(8'h10);
        cpu_wr(8'h12);
        chk("R6 erase blocked", cpu_rdata, 8'h10);
        chk("R6 no erase req", nvm_erase_req, 1'b0);
        cpu_wr(8'h00);
    endtask

    task automatic t_write_timer();
        cpu_wr(8'h04);
        cpu_wr(8'h06);
        chk("R7 wr started", cpu_rdata, 8'h06);
        chk("R7 req", {nvm_write_req, nvm_erase_req}, 2'b10);
        step(11);
        chk("R7 still busy", cpu_rdata, 8'h06);
        step(1);
        chk("R7 timer end", cpu_rdata, 8'h04);
        chk("R7 req drop", nvm_write_req, 1'b0);
    endtask

    task automatic t_write_done();
        cpu_wr(8'h06);
        step(3);
        done_pulse();
        chk("R7 done end", cpu_rdata, 8'h04);
        chk("R7 done req drop", nvm_write_req, 1'b0);
    endtask

    task automatic t_set_only();
        cpu_wr(8'h06);
        cpu_wr(8'h04);
        chk("R5 wr held", cpu_rdata, 8'h06);
        cpu_wr(8'h05);
        chk("R5 rd ignored busy", cpu_rdata, 8'h06);
        chk("R5 no strobe", nvm_rd_strobe, 1'b0);
        done_pulse();
        chk("R5 finished", cpu_rdata, 8'h04);
    endtask

    task automatic t_both();
        cpu_wr(8'h07);
        chk("R13 only wr", cpu_rdata, 8'h06);
        chk("R13 no strobe", nvm_rd_strobe, 1'b0);
        chk("R13 write req", nvm_write_req, 1'b1);
        done_pulse();
        chk("R13 finished", cpu_rdata, 8'h04);
    endtask

    task automatic t_erase();
        cpu_wr(8'h14);
        cpu_wr(8'h16);
        chk("R8 erase req", {nvm_write_req, nvm_erase_req}, 2'b01);
        chk("R8 busy", cpu_rdata, 8'h16);
        done_pulse();
        chk("R8 arm cleared", cpu_rdata, 8'h04);
        chk("R8 req drop", nvm_erase_req, 1'b0);
    endtask

    task automatic t_done_ignored();
        cpu_wr(8'h14);
        done_pulse();
        chk("R12 done ignored", cpu_rdata, 8'h14);
        cpu_wr(8'h04);
    endtask

    task automatic t_warm_abort();
        cpu_wr(8'hC4);
        cpu_wr(8'hC6);
        chk("R9 started", cpu_rdata, 8'hC6);
        step(2);
        warm_pulse();
        chk("R9 aborted", cpu_rdata, 8'hCC);
        chk("R9 req drop", nvm_write_req, 1'b0);
    endtask

    task automatic t_warm_idle();
        warm_pulse();
        chk("R10 err kept", cpu_rdata, 8'hCC);
    endtask

    task automatic t_err_clear();
        cpu_wr(8'hC6);
        chk("R11 started", cpu_rdata, 8'hCE);
        done_pulse();
        chk("R11 err cleared", cpu_rdata, 8'hC4);
    endtask

    initial begin
        step(2);
        t_reset();
        por_n = 1'b1;
        step(1);
        t_reset();
        t_layout();
        t_target();
        t_read();
        t_read_refused();
        t_wen_block();
        t_write_timer();
        t_write_done();
        t_set_only();
        t_both();
        t_erase();
        t_done_ignored();
        t_warm_abort();
        t_warm_idle();
        t_err_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule